// File: doc/BRIEF.md
# Wavefront-Scheduled Error-Diffusion Halftoner

This block turns a small 8-bit grey image of 8 columns and 6 rows into a one-bit-per-pixel halftone. Each pixel is corrected by a weighted share of the rounding error already made at four causal neighbours: left, upper-left, above and upper-right. The result is then compared against mid-scale, and the new rounding error is stored for the pixels that depend on it.

A pixel at column i and row j may be converted once all four of its neighbours are done. So every pixel is given the step number i + 2j. Pixels that share a step number have no dependency on one another, and they are converted together by a pool of four identical processing units. The whole image is finished in 18 clock steps. Software loads the image through a simple write port and pulses start. It then waits for the done flag and reads the 48-bit halftone vector.

Top module: `htone_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` is 0 and `halftone` is all zeros.
- R2: A write with `ld_we` high stores `ld_data` as the pixel at column i, row j when `ld_addr` = 8·j + i and is below 48. Writes presented while a conversion is running are ignored and do not affect the result of that run or of later runs.
- R3: A start pulse accepted while not converting clears `halftone` to zero and drops `done` on the next clock edge.
- R4: `done` rises on the 18th clock edge after the edge that accepts start.
- R5: Once high, `done` stays high until the next accepted start.
- R6: Bit 8·j + i of `halftone` is 1 exactly when CPV ≥ 128. CPV is the pixel value plus floor((7·eL + 1·eUL + 5·eU + 3·eUR) / 16), the terms being the stored errors of the left, upper-left, upper and upper-right neighbours. A neighbour outside the image contributes 0. The stored error of the pixel is CPV − 255 when the bit is 1, and CPV otherwise.
- R7: A start pulse while a conversion is running is ignored: the run neither restarts nor ends early.
- R8: Outside a conversion, and without an accepted start, `halftone` does not change.
- R9: In step s (counting from 0 at the first edge after start), exactly the pixels with i + 2j = s are converted. After k steps, precisely the bits with i + 2j < k can have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse to begin a conversion |
| ld_we | input | 1 | Pixel write enable |
| ld_addr | input | 6 | Pixel address, 8·row + column |
| ld_data | input | 8 | Pixel grey value |
| done | output | 1 | High when the last conversion has completed |
| halftone | output | 48 | One-bit result per pixel, bit 8·row + column |

## Verification
An error word that is corrupted or written to the wrong pixel spreads to the right and downward. It flips halftone bits in later wavefronts, so a mid-grey or textured image shows the mismatch when `done` rises, 18 edges after start. A wrong step counter or unit assignment shows up earlier, in the partly filled `halftone` vector observed in the middle of a run, as well as in the cycle on which `done` rises. Writes or start pulses that leak into a running conversion show up as a changed result or a wrong completion cycle.

// File: rtl/htone_pkg.sv
package htone_pkg;
  parameter int COLS    = 8;
  parameter int ROWS    = 6;
  parameter int PIX_W   = 8;
  parameter int ERR_W   = 9;
  parameter int UNITS   = 4;
  parameter int WGT_L   = 7;
  parameter int WGT_UL  = 1;
  parameter int WGT_U   = 5;
  parameter int WGT_UR  = 3;
  parameter int WGT_SH  = 4;   // sum of weights = 2**WGT_SH

  localparam int NPIX   = COLS * ROWS;
  localparam int STEPS  = COLS + 2 * (ROWS - 1);
  localparam int ADDR_W = $clog2(NPIX);
  localparam int STEP_W = $clog2(STEPS);
  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int SUM_W  = ERR_W + WGT_SH + 2;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam int THRESH  = 1 << (PIX_W - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } htone_state_e;
endpackage

// File: rtl/htone_ctrl.sv
module htone_ctrl
  import htone_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              run,
  output logic              fin,
  output logic              clr,
  output logic [STEP_W-1:0] step
);
  htone_state_e state_q;
  logic [STEP_W-1:0] step_q;
  logic last;

  assign last = (step_q == STEP_W'(STEPS - 1));
  assign clr  = start && (state_q != ST_RUN);
  assign run  = (state_q == ST_RUN);
  assign fin  = (state_q == ST_DONE);
  assign step = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (clr) begin
      state_q <= ST_RUN;
      step_q  <= '0;
    end else if (state_q == ST_RUN) begin
      if (last) begin
        state_q <= ST_DONE;
        step_q  <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/htone_sched.sv
module htone_sched
  import htone_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output logic [UNITS-1:0]  vld,
  output logic [COL_W-1:0]  col [UNITS],
  output logic [ROW_W-1:0]  row [UNITS]
);
  // Unit k takes the pixel with the k-th smallest row on wavefront col + 2*row.
  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    always_comb begin
      int w, jmin, j, i;
      w    = int'(step);
      jmin = (w > COLS - 1) ? (w - COLS + 2) / 2 : 0;
      j    = jmin + k;
      i    = w - 2 * j;
      vld[k] = (j < ROWS) && (i >= 0) && (i < COLS);
      col[k] = vld[k] ? COL_W'(i) : '0;
      row[k] = vld[k] ? ROW_W'(j) : '0;
    end
  end
endmodule

// File: rtl/htone_pe.sv
module htone_pe
  import htone_pkg::*;
(
  input  logic [PIX_W-1:0]        pix,
  input  logic signed [ERR_W-1:0] e_l,
  input  logic signed [ERR_W-1:0] e_ul,
  input  logic signed [ERR_W-1:0] e_u,
  input  logic signed [ERR_W-1:0] e_ur,
  output logic                    bit_o,
  output logic signed [ERR_W-1:0] err_o
);
  localparam logic signed [SUM_W-1:0] K_L   = SUM_W'(WGT_L);
  localparam logic signed [SUM_W-1:0] K_UL  = SUM_W'(WGT_UL);
  localparam logic signed [SUM_W-1:0] K_U   = SUM_W'(WGT_U);
  localparam logic signed [SUM_W-1:0] K_UR  = SUM_W'(WGT_UR);
  localparam logic signed [SUM_W-1:0] K_MAX = SUM_W'(PIX_MAX);
  localparam logic signed [SUM_W-1:0] K_TH  = SUM_W'(THRESH);

  logic signed [SUM_W-1:0] acc, avg, cpv, px;

  always_comb begin
    acc   = K_L * SUM_W'(e_l) + K_UL * SUM_W'(e_ul)
          + K_U * SUM_W'(e_u) + K_UR * SUM_W'(e_ur);
    avg   = acc >>> WGT_SH;
    px    = $signed(SUM_W'(pix));
    cpv   = px + avg;
    bit_o = (cpv >= K_TH);
    err_o = ERR_W'(bit_o ? (cpv - K_MAX) : cpv);
  end
endmodule

// File: rtl/htone_top.sv
module htone_top
  import htone_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [PIX_W-1:0]  ld_data,
  output logic              done,
  output logic [NPIX-1:0]   halftone
);
  logic              run, fin, clr;
  logic [STEP_W-1:0] step;
  logic [UNITS-1:0]  s_vld, u_vld;
  logic [COL_W-1:0]  u_col [UNITS];
  logic [ROW_W-1:0]  u_row [UNITS];
  logic [ADDR_W-1:0] u_idx [UNITS];
  logic [PIX_W-1:0]  u_pix [UNITS];
  logic signed [ERR_W-1:0] n_l [UNITS];
  logic signed [ERR_W-1:0] n_ul [UNITS];
  logic signed [ERR_W-1:0] n_u [UNITS];
  logic signed [ERR_W-1:0] n_ur [UNITS];
  logic signed [ERR_W-1:0] u_err [UNITS];
  logic [UNITS-1:0]  u_bit;

  logic [PIX_W-1:0]        pix_mem [NPIX];
  logic signed [ERR_W-1:0] err_mem [NPIX];
  logic [NPIX-1:0]         ht_q;

  htone_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .run  (run),
    .fin  (fin),
    .clr  (clr),
    .step (step)
  );

  htone_sched u_sched (
    .step(step),
    .vld (s_vld),
    .col (u_col),
    .row (u_row)
  );

  assign u_vld = run ? s_vld : '0;

  for (genvar k = 0; k < UNITS; k++) begin : g_pe
    assign u_idx[k] = ADDR_W'(u_row[k]) * ADDR_W'(COLS) + ADDR_W'(u_col[k]);
    assign u_pix[k] = pix_mem[u_idx[k]];

    always_comb begin
      n_l[k]  = '0;
      n_ul[k] = '0;
      n_u[k]  = '0;
      n_ur[k] = '0;
      if (u_vld[k]) begin
        if (u_col[k] != '0) n_l[k] = err_mem[u_idx[k] - 1'b1];
        if (u_row[k] != '0) begin
          n_u[k] = err_mem[u_idx[k] - ADDR_W'(COLS)];
          if (u_col[k] != '0)
            n_ul[k] = err_mem[u_idx[k] - ADDR_W'(COLS) - 1'b1];
          if (u_col[k] != COL_W'(COLS - 1))
            n_ur[k] = err_mem[u_idx[k] - ADDR_W'(COLS) + 1'b1];
        end
      end
    end

    htone_pe u_pe (
      .pix  (u_pix[k]),
      .e_l  (n_l[k]),
      .e_ul (n_ul[k]),
      .e_u  (n_u[k]),
      .e_ur (n_ur[k]),
      .bit_o(u_bit[k]),
      .err_o(u_err[k])
    );
  end

  // Pixel store: write-only port, closed while a run is active.
  always_ff @(posedge clk) begin
    if (ld_we && !run && (ld_addr < ADDR_W'(NPIX)))
      pix_mem[ld_addr] <= ld_data;
  end

  // Error store: cleared by an accepted start, written per wavefront.
  always_ff @(posedge clk) begin
    if (clr) begin
      for (int p = 0; p < NPIX; p++) err_mem[p] <= '0;
    end else begin
      for (int k = 0; k < UNITS; k++)
        if (u_vld[k]) err_mem[u_idx[k]] <= u_err[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ht_q <= '0;
    end else if (clr) begin
      ht_q <= '0;
    end else begin
      for (int k = 0; k < UNITS; k++)
        if (u_vld[k]) ht_q[u_idx[k]] <= u_bit[k];
    end
  end

  assign halftone = ht_q;
  assign done     = fin;
endmodule

// File: rtl/htone_chk.sv
module htone_chk
  import htone_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic             run,
  input logic [UNITS-1:0] u_vld,
  input logic [NPIX-1:0]  halftone
);
  logic [5:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= 6'd63;
    else if (start && !run) cyc <= '0;
    else if (cyc != 6'd63) cyc <= cyc + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!done && halftone == '0));

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !run) |=> (!done && halftone == '0));

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cyc == 6'(STEPS)));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cyc < 6'(STEPS - 1)) |=> (run && !done));

  // R8
  ht_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(halftone));

  // R9
  unit_busy_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (u_vld[0] && $countones(u_vld) <= UNITS));

  // R9
  unit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> (u_vld == '0));
endmodule

bind htone_top htone_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .run     (run),
  .u_vld   (u_vld),
  .halftone(halftone)
);

// File: tb/htone_top_bench.sv
module htone_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ld_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        done;
  logic [47:0] halftone;

  int tests = 0;
  int fails = 0;
  logic [7:0]  img [48];
  logic [47:0] exp_q [$];
  logic [47:0] last_exp = '0;
  logic        done_d = 1'b0;

  always #4 clk = ~clk;

  htone_top u_htone_top (
    .clk(clk), .rst(rst), .start(start), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .done(done), .halftone(halftone)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] model();
    int e [48];
    logic [47:0] r;
    r = '0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 8; i++) begin
        int el, eul, eu, eur, s, cpv;
        el  = (i > 0) ? e[j*8+i-1] : 0;
        eul = (i > 0 && j > 0) ? e[(j-1)*8+i-1] : 0;
        eu  = (j > 0) ? e[(j-1)*8+i] : 0;
        eur = (i < 7 && j > 0) ? e[(j-1)*8+i+1] : 0;
        s   = 7*el + eul + 5*eu + 3*eur;
        cpv = int'(img[j*8+i]) + (s >>> 4);
        r[j*8+i] = (cpv >= 128);
        e[j*8+i] = r[j*8+i] ? cpv - 255 : cpv;
      end
    return r;
  endfunction

  function automatic logic [47:0] front_mask(input int k);
    logic [47:0] m;
    m = '0;
    for (int p = 0; p < 48; p++) m[p] = ((p % 8) + 2 * (p / 8) < k);
    return m;
  endfunction

  // Monitor: compare each completed image against the scoreboard head (R6).
  always @(negedge clk) begin
    if (!rst && done && !done_d) begin
      logic [47:0] e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected result", halftone, '0);
      end else begin
        e = exp_q.pop_front();
        last_exp = e;
        check(halftone === e, "R6 halftone", halftone, e);
      end
    end
    done_d <= done;
  end

  task automatic fill(input int mode);
    for (int p = 0; p < 48; p++)
      case (mode)
        0: img[p] = 8'd0;
        1: img[p] = 8'd255;
        2: img[p] = 8'd128;
        3: img[p] = 8'(p * 5);
        4: img[p] = 8'(p * 37 + 11);
        5: img[p] = 8'd100;
        default: img[p] = ((p % 8) + (p / 8)) % 2 ? 8'd200 : 8'd40;
      endcase
  endtask

  task automatic load();
    for (int p = 0; p < 48; p++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 6'(p); ld_data = img[p];
    end
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 6'd50; ld_data = 8'hA5; // R2 out-of-range write
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // Driver: push expected result, start, and time the run.
  task automatic run_img(input bit disturb, input bit partial);
    int n;
    exp_q.push_back(model());
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(halftone == '0 && !done, "R3 clear on start", halftone, '0);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (disturb) begin
        ld_we   = (n >= 1 && n <= 10);
        ld_addr = 6'(n);
        ld_data = ~img[n % 48];
        start   = (n == 6); // R7 start while busy
      end
      if (partial && (n == 5 || n == 11))
        check(halftone == front_mask(n), "R9 wavefront order", halftone, front_mask(n));
    end
    ld_we = 1'b0; start = 1'b0;
    check(n == 18, disturb ? "R7 R4 completion cycle" : "R4 completion cycle",
          48'(n), 48'd18);
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && halftone == '0, "R1 reset state", halftone, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && halftone == '0, "R1 after reset", halftone, '0);

    fill(1); load(); run_img(1'b0, 1'b1);
    for (int m = 0; m < 7; m++) begin
      if (m == 1) continue;
      fill(m); load(); run_img(1'b0, 1'b0);
    end
    fill(4); load(); run_img(1'b1, 1'b0);   // R2 writes during run ignored
    run_img(1'b0, 1'b0);                    // R2 memory still holds the image
    repeat (6) @(negedge clk);
    check(done, "R5 done held", 48'(done), 48'd1);
    check(halftone == last_exp, "R8 result stable", halftone, last_exp);
    check(exp_q.size() == 0, "R6 all results seen", 48'(exp_q.size()), '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule